// File: doc/BRIEF.md
# Channel Status Block Sequencer

This block runs the frame-level bookkeeping of a two-channel digital audio transmitter. It watches a left/right frame-sync level and a one-cycle bit-period tick. From these it works out where each sub-frame starts and counts frames around a 192-frame channel status block. At every sub-frame start it latches the serial user and validity inputs. It also produces the channel status bit for that sub-frame, either from a serial status input or from a handful of dedicated control pins, each of which maps through a fixed encoding onto one status bit position.

The block also drives a block-boundary marker. The marker goes high when the first frame of a block begins. It goes low one bit period before the frame that carries status byte 16 begins, so it is high for 128 frames and low for 64. In transparent mode the block no longer drives the marker and holds it low. The block then reads a companion input, and a low-to-high change on that input restarts the block at frame 0. This lets a receiver set the block phase when the transmitter relays its stream. Line coding, preambles and the line driver sit downstream.

Top module: `cs_seq_top`

## Requirements
- R1: While `rstN` is low, `cOut`, `uOut`, `vOut` and `blkOut` are low one clock later. The remembered frame-sync level returns to 0, and the first left sub-frame start after reset is frame 0.
- R2: A sub-frame start is a clock with `bitTick` high in which `fsync` differs from its value at the previous tick. `fsync` high marks a left sub-frame and low marks a right one. On that clock `uIn` and `vIn` are captured. They appear on `uOut`/`vOut` one clock later and hold until the next sub-frame start.
- R3: The frame index advances by one at each left sub-frame start and wraps from 191 to 0. Both sub-frames of a frame use the same index, so `blkOut` rises every 192 frames.
- R4: With `serialSel` high, `cOut` takes the value of `cIn` captured at the sub-frame start.
- R5: With `serialSel` low, `cOut` in frame 0 equals `proSel`.
- R6: With `serialSel` low, `cOut` in frame 2 is the inverse of `copyCtl`.
- R7: With `serialSel` low, frame 24 carries `freqCode[1]` and frame 25 carries `freqCode[1] ^ freqCode[0]`. This gives codes 00, 01, 10 and 11 as bit pairs (24,25) of (0,0), (0,1), (1,1) and (1,0). Every other frame carries 0.
- R8: Outside transparent mode, `blkOut` goes high one clock after the left sub-frame start of frame 0.
- R9: Outside transparent mode, `blkOut` goes low one clock after the last bit tick of frame 127. That tick is found as the right sub-frame tick whose count from the sub-frame start equals the length of the left sub-frame of that frame, minus one.
- R10: With `transparent` high, `blkOut` is low one clock later. `blkIn` is sampled at every left sub-frame start, and a sample of 1 after a sample of 0 while `transparent` is high makes that frame frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-clock pulse per serial bit period |
| fsync | input | 1 | Frame sync level, high for left sub-frame |
| cIn | input | 1 | Serial channel status input |
| uIn | input | 1 | Serial user data input |
| vIn | input | 1 | Serial validity input |
| serialSel | input | 1 | 1: status bit from `cIn`, 0: from dedicated pins |
| proSel | input | 1 | Dedicated value for status bit 0 |
| copyCtl | input | 1 | Dedicated control for status bit 2, inverted sense |
| freqCode | input | 2 | Encoded sample-rate code for status bits 24 and 25 |
| transparent | input | 1 | Selects transparent mode |
| blkIn | input | 1 | Block restart input used in transparent mode |
| cOut | output | 1 | Channel status bit of current sub-frame |
| uOut | output | 1 | User bit of current sub-frame |
| vOut | output | 1 | Validity bit of current sub-frame |
| blkOut | output | 1 | Block-boundary marker |

## Verification
The bench targets the ends of the marker's high window. A design that counts sub-frames instead of frames, or that drops at the start of frame 128 instead of one bit earlier, moves the falling edge and shows up in the same clock. The wrap from 191 to 0 is checked by timing the gap between consecutive marker rises. A counter that wraps at 192 or 190 stretches or shrinks that period. The dedicated encodings are swept through all four frequency codes and both copy settings, which catches a swapped bit pair or a lost inversion on bit 2. A mid-run reset and a transparent-mode restart partway through a block check that the frame phase is reset correctly. They also check that the marker stays low whenever it is not driven.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  // strobes from the sequencing control to the bit datapath
  typedef struct packed {
    logic subStart;   // a sub-frame begins on this clock
    logic leftStart;  // that sub-frame is the left one
  } csStrb_t;
endpackage

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int HIGH_FRAMES      = 128,
  parameter int CNT_W            = 6,
  localparam int IDX_W           = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             fsync,
  input  logic             transparent,
  input  logic             blkIn,
  output csStrb_t          strb,
  output logic [IDX_W-1:0] curIdx,
  output logic             blkOut
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES_PER_BLOCK - 1);
  localparam logic [IDX_W-1:0] DROP_IDX = IDX_W'(HIGH_FRAMES - 1);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   LEN_ONE  = (CNT_W+1)'(1);

  logic             fsPrev;
  logic             isLeft;
  logic             started;
  logic             blkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W:0]   subLen;
  logic [IDX_W-1:0] frameIdx;

  logic             edgeDet;
  logic             realign;
  logic [IDX_W-1:0] wrapIdx;
  logic [IDX_W-1:0] nextIdx;
  logic [CNT_W-1:0] curCnt;
  logic             dropNow;

  always_comb begin
    edgeDet       = bitTick && (fsync != fsPrev);
    strb.subStart = edgeDet;
    strb.leftStart = edgeDet && fsync;
    realign       = transparent && blkIn && !blkPrev;
    wrapIdx       = (frameIdx == LAST_IDX) ? ZERO_IDX : frameIdx + IDX_W'(1);
    nextIdx       = (!started || realign) ? ZERO_IDX : wrapIdx;
    curIdx        = strb.leftStart ? nextIdx : frameIdx;
    if (edgeDet)
      curCnt = '0;
    else if (bitCnt == CNT_MAX)
      curCnt = bitCnt;
    else
      curCnt = bitCnt + CNT_W'(1);
    dropNow = bitTick && !edgeDet && !isLeft && (frameIdx == DROP_IDX) &&
              (({1'b0, curCnt} + LEN_ONE) == subLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev   <= 1'b0;
      isLeft   <= 1'b0;
      started  <= 1'b0;
      blkPrev  <= 1'b0;
      bitCnt   <= '0;
      subLen   <= '0;
      frameIdx <= '0;
      blkOut   <= 1'b0;
    end else begin
      if (bitTick) begin
        fsPrev <= fsync;
        bitCnt <= curCnt;
      end
      if (edgeDet) begin
        isLeft <= fsync;
        subLen <= {1'b0, bitCnt} + LEN_ONE;
      end
      if (strb.leftStart) begin
        frameIdx <= nextIdx;
        started  <= 1'b1;
        blkPrev  <= blkIn;
      end
      if (transparent)
        blkOut <= 1'b0;
      else if (strb.leftStart && (nextIdx == ZERO_IDX))
        blkOut <= 1'b1;
      else if (dropNow)
        blkOut <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_seq_dp.sv
module cs_seq_dp
  import cs_seq_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int PRO_POS          = 0,
  parameter int COPY_POS         = 2,
  parameter int FREQ_A_POS       = 24,
  parameter int FREQ_B_POS       = 25,
  localparam int IDX_W           = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  csStrb_t          strb,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             serialSel,
  input  logic             cIn,
  input  logic             uIn,
  input  logic             vIn,
  input  logic             proSel,
  input  logic             copyCtl,
  input  logic [1:0]       freqCode,
  output logic             cOut,
  output logic             uOut,
  output logic             vOut
);
  localparam logic [IDX_W-1:0] PRO_IDX    = IDX_W'(PRO_POS);
  localparam logic [IDX_W-1:0] COPY_IDX   = IDX_W'(COPY_POS);
  localparam logic [IDX_W-1:0] FREQ_A_IDX = IDX_W'(FREQ_A_POS);
  localparam logic [IDX_W-1:0] FREQ_B_IDX = IDX_W'(FREQ_B_POS);

  logic dedBit;
  logic cNext;

  always_comb begin
    dedBit = 1'b0;
    if (curIdx == PRO_IDX)    dedBit = proSel;
    if (curIdx == COPY_IDX)   dedBit = ~copyCtl;
    if (curIdx == FREQ_A_IDX) dedBit = freqCode[1];
    if (curIdx == FREQ_B_IDX) dedBit = freqCode[1] ^ freqCode[0];
    cNext = serialSel ? cIn : dedBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cOut <= 1'b0;
      uOut <= 1'b0;
      vOut <= 1'b0;
    end else if (strb.subStart) begin
      cOut <= cNext;
      uOut <= uIn;
      vOut <= vIn;
    end
  end
endmodule

// File: rtl/cs_seq_top.sv
module cs_seq_top
  import cs_seq_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int HIGH_FRAMES      = 128,
  parameter int CNT_W            = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       fsync,
  input  logic       cIn,
  input  logic       uIn,
  input  logic       vIn,
  input  logic       serialSel,
  input  logic       proSel,
  input  logic       copyCtl,
  input  logic [1:0] freqCode,
  input  logic       transparent,
  input  logic       blkIn,
  output logic       cOut,
  output logic       uOut,
  output logic       vOut,
  output logic       blkOut
);
  localparam int IDX_W = $clog2(FRAMES_PER_BLOCK);

  csStrb_t          strb;
  logic [IDX_W-1:0] curIdx;

  cs_seq_ctrl #(
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK),
    .HIGH_FRAMES     (HIGH_FRAMES),
    .CNT_W           (CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .fsync      (fsync),
    .transparent(transparent),
    .blkIn      (blkIn),
    .strb       (strb),
    .curIdx     (curIdx),
    .blkOut     (blkOut)
  );

  cs_seq_dp #(
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .curIdx   (curIdx),
    .serialSel(serialSel),
    .cIn      (cIn),
    .uIn      (uIn),
    .vIn      (vIn),
    .proSel   (proSel),
    .copyCtl  (copyCtl),
    .freqCode (freqCode),
    .cOut     (cOut),
    .uOut     (uOut),
    .vOut     (vOut)
  );
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk
  import cs_seq_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  localparam int IDX_W           = $clog2(FRAMES_PER_BLOCK)
) (
  input logic             clk,
  input logic             rstN,
  input logic             serialSel,
  input logic             transparent,
  input logic             cIn,
  input logic             uIn,
  input logic             vIn,
  input csStrb_t          strb,
  input logic [IDX_W-1:0] curIdx,
  input logic             cOut,
  input logic             uOut,
  input logic             vOut,
  input logic             blkOut
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES_PER_BLOCK - 1);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |=> (!cOut && !uOut && !vOut && !blkOut));

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.subStart |=> $stable({cOut, uOut, vOut}));

  // R2
  uv_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.subStart |=> (uOut == $past(uIn)) && (vOut == $past(vIn)));

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curIdx <= LAST_IDX);

  // R4
  serial_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.subStart && serialSel) |=> (cOut == $past(cIn)));

  // R8
  rise_on_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.leftStart |=> !$rose(blkOut));

  // R10
  transp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    transparent |=> !blkOut);
endmodule

bind cs_seq_top cs_seq_chk #(
  .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .serialSel  (serialSel),
  .transparent(transparent),
  .cIn        (cIn),
  .uIn        (uIn),
  .vIn        (vIn),
  .strb       (strb),
  .curIdx     (curIdx),
  .cOut       (cOut),
  .uOut       (uOut),
  .vOut       (vOut),
  .blkOut     (blkOut)
);

// File: tb/cs_seq_top_tb_top.sv
`timescale 1ns/1ps
module cs_seq_top_tb_top;
  localparam int SUB_TICKS  = 32;
  localparam int FRAME_CLKS = SUB_TICKS * 2 * 2;
  localparam int BLOCK      = 192;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       fsync = 1'b0;
  logic       cIn = 1'b0, uIn = 1'b0, vIn = 1'b0;
  logic       serialSel = 1'b1, proSel = 1'b0, copyCtl = 1'b0;
  logic [1:0] freqCode = 2'b00;
  logic       transparent = 1'b0, blkIn = 1'b0;
  logic       cOut, uOut, vOut, blkOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  cs_seq_top dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .fsync(fsync),
    .cIn(cIn), .uIn(uIn), .vIn(vIn), .serialSel(serialSel),
    .proSel(proSel), .copyCtl(copyCtl), .freqCode(freqCode),
    .transparent(transparent), .blkIn(blkIn),
    .cOut(cOut), .uOut(uOut), .vOut(vOut), .blkOut(blkOut)
  );

  always #4 clk = ~clk;

  // stimulus generator: tick every other clock, 32 ticks per sub-frame
  bit drvRun = 1'b0;
  bit tog = 1'b0;
  int tickInSub = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    if (!drvRun) begin
      bitTick = 1'b0; fsync = 1'b0; tog = 1'b0; tickInSub = 0;
    end else begin
      tog = ~tog;
      bitTick = tog;
      if (tog) begin
        tickInSub++;
        if (tickInSub == SUB_TICKS) begin
          fsync = ~fsync;
          tickInSub = 0;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cIn = lfsr[0]; uIn = lfsr[5]; vIn = lfsr[9];
      end
    end
  end

  // behavioural reference model
  bit    mFsPrev, mStarted, mLeft, mBlkPrev, isEdge;
  int    mFrame, mPos;
  logic  expC = 0, expU = 0, expV = 0, expBlk = 0;
  string tagC = "R1", tagBlk = "R1", tagUV = "R1";

  function automatic logic dedRef(int idx);
    case (idx)
      0:  return proSel;                    // R5
      2:  return ~copyCtl;                  // R6
      24: return freqCode[1];               // R7
      25: return freqCode[1] ^ freqCode[0]; // R7
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFsPrev = 0; mStarted = 0; mLeft = 0; mBlkPrev = 0;
      mFrame = 0; mPos = 0;
      expC = 0; expU = 0; expV = 0; expBlk = 0;
      tagC = "R1"; tagBlk = "R1"; tagUV = "R1";
    end else begin
      if (bitTick) begin
        isEdge = (fsync != mFsPrev);
        mFsPrev = fsync;
        if (isEdge) begin
          mPos = 0;
          mLeft = fsync;
          if (fsync) begin
            if (!mStarted || (transparent && blkIn && !mBlkPrev)) mFrame = 0;
            else mFrame = (mFrame + 1) % BLOCK;
            mStarted = 1;
            mBlkPrev = blkIn;
            if (!transparent && mFrame == 0) begin expBlk = 1; tagBlk = "R8"; end
          end
          expU = uIn; expV = vIn; tagUV = "R2";
          if (serialSel) begin
            expC = cIn; tagC = "R4";
          end else begin
            expC = dedRef(mFrame);
            tagC = (mFrame == 0) ? "R5" : (mFrame == 2) ? "R6" :
                   (mFrame == 24 || mFrame == 25) ? "R7" : "R3";
          end
        end else begin
          mPos++;
          if (!mLeft && mFrame == 127 && mPos == SUB_TICKS - 1) begin
            expBlk = 0; tagBlk = "R9";
          end
        end
      end
      if (transparent) begin expBlk = 0; tagBlk = "R10"; end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  int clkNo = 0;
  int lastRise = -1;
  logic blkSeen = 0;
  always @(negedge clk) begin
    clkNo++;
    if (clkNo > 2 && !finished) begin
      chk(tagC,  "cOut",   cOut,   expC);
      chk(tagUV, "uOut",   uOut,   expU);
      chk(tagUV, "vOut",   vOut,   expV);
      chk(tagBlk, "blkOut", blkOut, expBlk);
      // R3: block period measured between marker rises
      if (!rstN || transparent) lastRise = -1;
      else if (blkOut === 1'b1 && blkSeen === 1'b0) begin
        if (lastRise >= 0) begin
          checks++;
          if (clkNo - lastRise != BLOCK * FRAME_CLKS) begin
            fails++;
            $display("FAIL R3 block period: actual %0d expected %0d",
                     clkNo - lastRise, BLOCK * FRAME_CLKS);
          end
        end
        lastRise = clkNo;
      end
      blkSeen = blkOut;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (6) @(negedge clk);
    rstN = 1'b1; drvRun = 1'b1;
    // R4: serial status source, R3 block period
    repeat (200 * FRAME_CLKS) @(negedge clk);
    // R5 R6 R7: dedicated sources, all frequency codes
    serialSel = 1'b0; proSel = 1'b1; copyCtl = 1'b1; freqCode = 2'b01;
    repeat (BLOCK * FRAME_CLKS) @(negedge clk);
    proSel = 1'b0; copyCtl = 1'b0; freqCode = 2'b10;
    repeat (BLOCK * FRAME_CLKS) @(negedge clk);
    copyCtl = 1'b1; freqCode = 2'b11;
    repeat (BLOCK * FRAME_CLKS) @(negedge clk);
    // R1: reset in mid-block restarts at frame 0
    rstN = 1'b0; drvRun = 1'b0;
    repeat (6) @(negedge clk);
    rstN = 1'b1; drvRun = 1'b1; freqCode = 2'b00; proSel = 1'b1;
    repeat (40 * FRAME_CLKS) @(negedge clk);
    // R10: transparent mode with a realign pulse
    transparent = 1'b1;
    repeat (30 * FRAME_CLKS) @(negedge clk);
    blkIn = 1'b1;
    repeat (10 * FRAME_CLKS) @(negedge clk);
    blkIn = 1'b0;
    repeat (140 * FRAME_CLKS) @(negedge clk);
    // R8: marker resumes at the realigned frame 0
    transparent = 1'b0;
    repeat (150 * FRAME_CLKS) @(negedge clk);
    finish_run();
  end
endmodule